// File: doc/BRIEF.md
# Horner Polynomial Evaluation Unit

This block evaluates a polynomial of up to `MAX_N` terms at a signed Q15 point `x` using Horner's nesting. One fused step is spent per coefficient: the running sum is multiplied by `x` and added to the coefficient loaded the step before, while the next coefficient is fetched into the addend register. An N-term polynomial therefore costs N arithmetic steps, not the 2N a separate multiply and add would need.

The coefficients live in an external table with a synchronous read port. Entry 0 holds the highest-order term and entry N-1 holds the constant term. A caller fills the table, presents `x` and the term count, and pulses `start_i`. The unit reads the table in ascending order, runs the recurrence in a 40-bit accumulator and stores a saturated 16-bit result. It then raises `done_o` for one cycle.

Top module: `horner_eval`

## Requirements
- R1: While reset is high and on the cycle after it, `done_o` and `coef_rd_o` are 0 and `result_o` is 0.
- R2: For an accepted job of N terms, the unit reads table addresses 0, 1, …, N-1 in ascending order, one per cycle, each exactly once. It never asserts `coef_rd_o` with an address at or above N. It does not read while idle.
- R3: With addend B initialised to table[0]·2^16 and accumulator A cleared, each of the N steps sets A = B + 2·x·A[31:16], where x and A[31:16] are signed 16-bit. The same step loads B with table[k+1]·2^16 when that entry exists. Otherwise B is left unchanged.
- R4: The stored result is A[31:16] when A lies within the signed 32-bit range. It is 0x7FFF when A is above that range and 0x8000 when A is below it.
- R5: `done_o` is high for exactly one cycle. It rises N+3 clock edges after the edge that accepted `start_i`.
- R6: A `start_i` pulse that arrives while a job is running is ignored. The running job's result, read count and single `done_o` pulse are unchanged.
- R7: A `start_i` with a term count of 0, or of more than `MAX_N`, is ignored. No table read and no `done_o` follow.
- R8: `result_o` holds its value between `done_o` pulses.
- R9: With N = 1 the result equals table[0] for any x.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start request, taken only when idle |
| x_i | input | DW | Evaluation point, signed Q15, latched at start |
| nterms_i | input | CNT_W | Number of coefficients N, valid from 1 to MAX_N |
| coef_addr_o | output | ADDR_W | Coefficient table address |
| coef_rd_o | output | 1 | Coefficient table read enable |
| coef_data_i | input | DW | Coefficient read data, valid one cycle after the read |
| done_o | output | 1 | One-cycle completion pulse |
| result_o | output | DW | Saturated Q15 result |

## Verification
The checker watches these rules on every cycle:
- the shape of the `done_o` pulse and its N+3 latency, measured from the accepting edge;
- that table reads stay below N, step up by one address at a time, and stop while idle;
- that `result_o` holds between completions.

Arithmetic correctness cannot be seen one cycle at a time. Only the bench scenarios show it:
- hand-worked vectors;
- saturation at both rails;
- the single-term case;
- randomised jobs of every length from 1 to 8, compared with a bit-accurate recurrence model.

The scenarios also cover a restart attempt while busy and out-of-range term counts.

// File: rtl/horner_pkg.sv
package horner_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRIME,
    ST_LOADB,
    ST_RUN,
    ST_FINISH
  } hstate_t;

  typedef struct packed {
    logic start;       // latch x, clear accumulator
    logic load_first;  // first coefficient into addend register
    logic step;        // one Horner multiply-add
    logic load_next;   // next coefficient into addend register
    logic store;       // saturate and store result
  } dp_ctrl_t;

endpackage

// File: rtl/horner_ctrl.sv
module horner_ctrl
  import horner_pkg::*;
#(
  parameter int MAX_N = 8,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] nterms_i,
  output logic             accept_o,
  output dp_ctrl_t         ctl_o,
  output logic             done_o
);

  hstate_t          state_q;
  logic [CNT_W-1:0] n_q;
  logic [CNT_W-1:0] step_q;
  logic             done_q;
  logic             count_ok;
  logic             last_step;
  logic [CNT_W:0]   step_nxt;

  assign count_ok  = (nterms_i != '0) && (nterms_i <= CNT_W'(MAX_N));
  assign accept_o  = (state_q == ST_IDLE) && start_i && count_ok;
  assign step_nxt  = {1'b0, step_q} + 1'b1;
  assign last_step = (step_nxt == {1'b0, n_q});

  always_comb begin
    ctl_o            = '0;
    ctl_o.start      = accept_o;
    ctl_o.load_first = (state_q == ST_LOADB);
    ctl_o.step       = (state_q == ST_RUN);
    ctl_o.load_next  = (state_q == ST_RUN) && (step_nxt < {1'b0, n_q});
    ctl_o.store      = (state_q == ST_FINISH);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      n_q     <= '0;
      step_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= (state_q == ST_FINISH);
      unique case (state_q)
        ST_IDLE: begin
          if (accept_o) begin
            n_q     <= nterms_i;
            state_q <= ST_PRIME;
          end
        end
        ST_PRIME: state_q <= ST_LOADB;
        ST_LOADB: begin
          step_q  <= '0;
          state_q <= ST_RUN;
        end
        ST_RUN: begin
          if (last_step) state_q <= ST_FINISH;
          else           step_q  <= step_nxt[CNT_W-1:0];
        end
        ST_FINISH: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign done_o = done_q;

endmodule

// File: rtl/horner_fetch.sv
module horner_fetch #(
  parameter int MAX_N  = 8,
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go_i,
  input  logic [CNT_W-1:0]  nterms_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              rd_o
);

  logic              active_q;
  logic [CNT_W-1:0]  idx_q;
  logic [CNT_W-1:0]  lim_q;
  logic [ADDR_W-1:0] addr_q;
  logic              rd_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      lim_q    <= '0;
      addr_q   <= '0;
      rd_q     <= 1'b0;
    end else if (go_i) begin
      active_q <= 1'b1;
      lim_q    <= nterms_i;
      idx_q    <= CNT_W'(1);
      addr_q   <= '0;
      rd_q     <= 1'b1;
    end else if (active_q) begin
      if (idx_q < lim_q) begin
        addr_q <= idx_q[ADDR_W-1:0];
        rd_q   <= 1'b1;
        idx_q  <= idx_q + 1'b1;
      end else begin
        rd_q     <= 1'b0;
        active_q <= 1'b0;
      end
    end else begin
      rd_q <= 1'b0;
    end
  end

  assign addr_o = addr_q;
  assign rd_o   = rd_q;

endmodule

// File: rtl/horner_datapath.sv
module horner_datapath
  import horner_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 40
) (
  input  logic          clk,
  input  logic          rst,
  input  dp_ctrl_t      ctl_i,
  input  logic [DW-1:0] x_i,
  input  logic [DW-1:0] coef_i,
  output logic [DW-1:0] result_o
);

  localparam int PW    = 2 * DW;
  localparam int GUARD = AW - PW;

  logic signed [DW-1:0] t_q;
  logic signed [AW-1:0] a_q;
  logic signed [AW-1:0] b_q;
  logic        [DW-1:0] res_q;

  logic signed [DW-1:0] a_hi;
  logic signed [PW-1:0] prod;
  logic signed [AW-1:0] prod_ext;
  logic signed [AW-1:0] mac;
  logic signed [AW-1:0] coef_ext;
  logic                 in_range;
  logic        [DW-1:0] sat_val;

  assign coef_ext = {{GUARD{coef_i[DW-1]}}, coef_i, {DW{1'b0}}};
  assign a_hi     = a_q[PW-1:DW];
  assign prod     = t_q * a_hi;
  assign prod_ext = {{GUARD{prod[PW-1]}}, prod};
  assign mac      = b_q + (prod_ext <<< 1);

  // guard bits and the 32-bit sign bit must all agree
  assign in_range = (a_q[AW-1:PW-1] == {(GUARD+1){1'b0}}) ||
                    (a_q[AW-1:PW-1] == {(GUARD+1){1'b1}});

  always_comb begin
    if (in_range)    sat_val = a_q[PW-1:DW];
    else if (a_q[AW-1]) sat_val = {1'b1, {(DW-1){1'b0}}};
    else             sat_val = {1'b0, {(DW-1){1'b1}}};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      t_q   <= '0;
      a_q   <= '0;
      b_q   <= '0;
      res_q <= '0;
    end else begin
      if (ctl_i.start) begin
        t_q <= x_i;
        a_q <= '0;
      end
      if (ctl_i.load_first) b_q <= coef_ext;
      if (ctl_i.step) begin
        a_q <= mac;
        if (ctl_i.load_next) b_q <= coef_ext;
      end
      if (ctl_i.store) res_q <= sat_val;
    end
  end

  assign result_o = res_q;

endmodule

// File: rtl/horner_eval.sv
module horner_eval
  import horner_pkg::*;
#(
  parameter int DW     = 16,
  parameter int AW     = 40,
  parameter int MAX_N  = 8,
  parameter int CNT_W  = $clog2(MAX_N + 1),
  parameter int ADDR_W = (MAX_N > 1) ? $clog2(MAX_N) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [DW-1:0]     x_i,
  input  logic [CNT_W-1:0]  nterms_i,
  output logic [ADDR_W-1:0] coef_addr_o,
  output logic              coef_rd_o,
  input  logic [DW-1:0]     coef_data_i,
  output logic              done_o,
  output logic [DW-1:0]     result_o
);

  dp_ctrl_t ctl;
  logic     accept;

  horner_ctrl #(
    .MAX_N (MAX_N),
    .CNT_W (CNT_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start_i  (start_i),
    .nterms_i (nterms_i),
    .accept_o (accept),
    .ctl_o    (ctl),
    .done_o   (done_o)
  );

  horner_fetch #(
    .MAX_N  (MAX_N),
    .CNT_W  (CNT_W),
    .ADDR_W (ADDR_W)
  ) u_fetch (
    .clk      (clk),
    .rst      (rst),
    .go_i     (accept),
    .nterms_i (nterms_i),
    .addr_o   (coef_addr_o),
    .rd_o     (coef_rd_o)
  );

  horner_datapath #(
    .DW (DW),
    .AW (AW)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .ctl_i    (ctl),
    .x_i      (x_i),
    .coef_i   (coef_data_i),
    .result_o (result_o)
  );

endmodule

// File: rtl/horner_eval_chk.sv
module horner_eval_chk #(
  parameter int DW     = 16,
  parameter int MAX_N  = 8,
  parameter int CNT_W  = 4,
  parameter int ADDR_W = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              start_i,
  input logic [CNT_W-1:0]  nterms_i,
  input logic [ADDR_W-1:0] coef_addr_o,
  input logic              coef_rd_o,
  input logic              done_o,
  input logic [DW-1:0]     result_o
);

  localparam int LW = CNT_W + 2;

  logic             busy_c;
  logic [CNT_W-1:0] n_c;
  logic [LW-1:0]    lat_c;
  logic             acc_c;

  assign acc_c = start_i && (!busy_c || done_o) &&
                 (nterms_i != '0) && (nterms_i <= CNT_W'(MAX_N));

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_c <= 1'b0;
      n_c    <= '0;
      lat_c  <= '0;
    end else if (acc_c) begin
      busy_c <= 1'b1;
      n_c    <= nterms_i;
      lat_c  <= '0;
    end else if (done_o) begin
      busy_c <= 1'b0;
    end else if (busy_c) begin
      lat_c <= lat_c + 1'b1;
    end
  end

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (!done_o && !coef_rd_o && result_o == '0));

  // R5
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5
  done_latency_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (lat_c == LW'(n_c) + LW'(3)));

  // R2
  read_bound_chk: assert property (@(posedge clk) disable iff (rst)
    coef_rd_o |-> (busy_c && CNT_W'(coef_addr_o) < n_c));

  // R2
  read_order_chk: assert property (@(posedge clk) disable iff (rst)
    (coef_rd_o && $past(coef_rd_o)) |-> (coef_addr_o == $past(coef_addr_o) + 1'b1));

  // R6
  done_owner_chk: assert property (@(posedge clk) disable iff (rst)
    done_o |-> busy_c);

  // R8
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done_o |-> $stable(result_o));

endmodule

bind horner_eval horner_eval_chk #(
  .DW     (DW),
  .MAX_N  (MAX_N),
  .CNT_W  (CNT_W),
  .ADDR_W (ADDR_W)
) u_chk (.*);

// File: tb/horner_eval_tb.sv
module horner_eval_tb;

  localparam int DW     = 16;
  localparam int MAX_N  = 8;
  localparam int CNT_W  = $clog2(MAX_N + 1);
  localparam int ADDR_W = $clog2(MAX_N);

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start_i = 1'b0;
  logic [DW-1:0]     x_i = '0;
  logic [CNT_W-1:0]  nterms_i = '0;
  logic [ADDR_W-1:0] coef_addr_o;
  logic              coef_rd_o;
  logic [DW-1:0]     coef_data_i = '0;
  logic              done_o;
  logic [DW-1:0]     result_o;

  logic [DW-1:0] mem [MAX_N];

  int n_checks = 0;
  int n_bad    = 0;
  int rd_cnt   = 0;
  int done_cnt = 0;
  bit finished = 0;
  int exp_q[$];
  string req_q[$];

  always #2.5 clk = ~clk;

  horner_eval u_dut (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .x_i         (x_i),
    .nterms_i    (nterms_i),
    .coef_addr_o (coef_addr_o),
    .coef_rd_o   (coef_rd_o),
    .coef_data_i (coef_data_i),
    .done_o      (done_o),
    .result_o    (result_o)
  );

  // synchronous coefficient table
  always @(posedge clk) begin
    if (coef_rd_o) coef_data_i <= mem[coef_addr_o];
    if (coef_rd_o) rd_cnt <= rd_cnt + 1;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // bit-accurate recurrence from R3/R4
  function automatic int model(input int n, input logic [DW-1:0] xv);
    longint a, b, ah, xs;
    xs = longint'($signed(xv));
    a  = 0;
    b  = longint'($signed(mem[0])) * 65536;
    for (int k = 0; k < n; k++) begin
      ah = (a >>> 16) & 64'hFFFF;
      if (ah >= 32768) ah = ah - 65536;
      a = b + 2 * xs * ah;
      if (k + 1 < n) b = longint'($signed(mem[k+1])) * 65536;
    end
    if (a > 64'sd2147483647)       return 32'h7FFF;
    else if (a < -64'sd2147483648) return 32'h8000;
    else                           return int'((a >>> 16) & 64'hFFFF);
  endfunction

  // monitor: pops expected results as done pulses appear
  always @(negedge clk) begin
    if (!rst && done_o) begin
      done_cnt++;
      if (exp_q.size() == 0) begin
        check(0, "R6 unexpected done", int'(result_o), 0);
      end else begin
        int e;
        string r;
        e = exp_q.pop_front();
        r = req_q.pop_front();
        check(int'(result_o) == e, r, int'(result_o), e);
      end
    end
  end

  // driver: exp < 0 selects the model
  task automatic run_job(input int n, input logic [DW-1:0] xv, input int exp, input string req);
    int lat;
    @(negedge clk);
    exp_q.push_back(exp < 0 ? model(n, xv) : exp);
    req_q.push_back(req);
    x_i      = xv;
    nterms_i = CNT_W'(n);
    start_i  = 1'b1;
    rd_cnt   = 0;
    @(posedge clk);
    @(negedge clk);
    start_i = 1'b0;
    lat = 0;
    do begin
      @(posedge clk);
      @(negedge clk);
      lat++;
    end while (!done_o && lat < 40);
    check(lat == n + 3, "R5 latency", lat, n + 3);
    check(rd_cnt == n, "R2 read count", rd_cnt, n);
    @(negedge clk);
    check(done_o == 1'b0, "R5 pulse width", int'(done_o), 0);
  endtask

  initial begin
    repeat (2) @(posedge clk);
    @(negedge clk);
    // R1
    check(done_o == 0 && coef_rd_o == 0 && result_o == 0, "R1 reset state",
          int'({done_o, coef_rd_o, result_o}), 0);
    rst = 1'b0;
    @(negedge clk);

    // R3 hand vector: x=0.5, c1=0.25, c0=0.125 -> 0.25
    mem[0] = 16'h2000; mem[1] = 16'h1000;
    run_job(2, 16'h4000, 32'h2000, "R3 hand vector");
    // R3 three terms: x=0.5, [0.5, 0, 0.25] -> 0.25 + 0.5*0.5*0.5 = 0.375
    mem[0] = 16'h4000; mem[1] = 16'h0000; mem[2] = 16'h2000;
    run_job(3, 16'h4000, 32'h3000, "R3 three terms");

    // R4 saturation at both rails
    mem[0] = 16'h7FFF; mem[1] = 16'h7FFF;
    run_job(2, 16'h7FFF, 32'h7FFF, "R4 positive saturation");
    mem[0] = 16'h7FFF; mem[1] = 16'h8000;
    run_job(2, 16'h8000, 32'h8000, "R4 negative saturation");

    // R9 single term ignores x
    mem[0] = 16'hA5C3;
    run_job(1, 16'h7FFF, 32'hA5C3, "R9 single term");
    run_job(1, 16'h8000, 32'hA5C3, "R9 single term");

    // R8 result holds
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check(result_o == 16'hA5C3, "R8 hold", int'(result_o), 32'hA5C3);
    end

    // R7 count 0 and above MAX_N ignored
    foreach (exp_q[i]) ;
    for (int v = 0; v < 16; v += 9) begin
      int dc;
      dc = done_cnt;
      @(negedge clk);
      rd_cnt   = 0;
      nterms_i = CNT_W'(v);
      start_i  = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (20) @(negedge clk);
      check(rd_cnt == 0, "R7 no reads", rd_cnt, 0);
      check(done_cnt == dc, "R7 no done", done_cnt - dc, 0);
      check(result_o == 16'hA5C3, "R7 result kept", int'(result_o), 32'hA5C3);
    end
    begin
      int dc;
      dc = done_cnt;
      @(negedge clk);
      rd_cnt   = 0;
      nterms_i = CNT_W'(15);
      start_i  = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (20) @(negedge clk);
      check(rd_cnt == 0 && done_cnt == dc, "R7 count 15", rd_cnt, 0);
    end

    // R6 start while busy is ignored
    for (int k = 0; k < MAX_N; k++) mem[k] = DW'($urandom);
    begin
      int dc;
      dc = done_cnt;
      @(negedge clk);
      exp_q.push_back(model(5, 16'h3333));
      req_q.push_back("R6 busy restart");
      x_i = 16'h3333; nterms_i = CNT_W'(5); start_i = 1'b1; rd_cnt = 0;
      @(negedge clk);
      start_i = 1'b0;
      repeat (3) @(negedge clk);
      x_i = 16'h9999; nterms_i = CNT_W'(8); start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      repeat (25) @(negedge clk);
      check(done_cnt == dc + 1, "R6 single done", done_cnt - dc, 1);
      check(rd_cnt == 5, "R6 read count", rd_cnt, 5);
    end

    // R3 random jobs over every length
    for (int j = 0; j < 48; j++) begin
      int n;
      n = (j % MAX_N) + 1;
      for (int k = 0; k < MAX_N; k++) mem[k] = DW'($urandom);
      run_job(n, DW'($urandom), -1, "R3 random job");
    end

    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, "R5 missing done", exp_q.size(), 0);
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(0, "watchdog", 0, 1);
      $display("test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
    end
  end

endmodule